// File: doc/BRIEF.md
# Multiplexed ADC Host Sequencer

This block sits on the host side of a serial successive-approximation converter with an eight-input analog multiplexer. It accepts one 7-bit channel configuration per request. For each request it drives a single framing line high to start a conversion and holds it high for the worst-case conversion time. It then drops the line and clocks a full result frame: the configuration word goes out on the data-out pin while the converter's result comes in on the data-in pin.

The converter applies a configuration word to the conversion that follows it, not to the one whose result is being read. The block therefore labels every delivered result with the configuration sent in the frame before. The first frame after reset produces no result. Between frames it keeps the framing line low for at least the acquisition time. If the word just sent asked the converter to sleep, it waits for a much longer wake-up time instead. All times are parameters counted in system clock cycles. The serial clock is the system clock divided by twice `SCK_DIV`, and a divider below 5 is rejected at elaboration so that rising-edge capture stays at or below one tenth of the system clock.

Top module: `adc_mux_sequencer`

## Requirements
- R1: While reset is held and in the first cycle after it, `adc_cnv`, `adc_sclk`, `adc_mosi` and `res_valid` are low and `req_ready` is high.
- R2: An accepted request raises `adc_cnv` on the next clock. The line then stays high for exactly `CONV_CYCLES` clocks with `adc_sclk` low and `req_ready` low, and each rise corresponds to exactly one accepted request.
- R3: After `adc_cnv` falls, exactly `RES_BITS` serial clock pulses follow. Every low and every high phase, including the first low phase after the fall, lasts exactly `SCK_DIV` clocks, and the serial clock idles low.
- R4: The configuration goes out MSB first, one bit per serial clock. The bits are, from bit 6 down: single-ended select, odd/sign, select bit 1, select bit 0, common-pin select, unipolar, sleep (bit 0). `adc_mosi` changes only while the serial clock is low and is low for every pulse after the seventh.
- R5: `adc_miso` is sampled on each rising serial clock edge and assembled MSB first into `res_data`, passed through unchanged: straight binary in unipolar mode, two's complement in bipolar mode.
- R6: `res_valid` is a one-cycle pulse in the cycle the last falling serial clock edge appears. `res_cfg` holds the configuration sent in the previous frame. No result is produced for the first frame after reset.
- R7: After a frame whose word had the sleep bit clear, at least `ACQ_CYCLES` clocks pass between the last falling serial clock edge and the next rise of `adc_cnv`.
- R8: After a frame whose word had the sleep bit (bit 0) set, at least `WAKE_CYCLES` clocks pass before the next rise of `adc_cnv`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Configuration request present |
| req_ready | output | 1 | Sequencer can start a conversion this cycle |
| req_cfg | input | 7 | Configuration word for the next frame (bit 6 sent first) |
| res_valid | output | 1 | One-cycle strobe for a new result |
| res_data | output | RES_BITS | Result read in the frame just finished |
| res_cfg | output | 7 | Configuration that produced `res_data` |
| adc_cnv | output | 1 | Convert-start / transfer-frame line to the converter |
| adc_sclk | output | 1 | Serial clock to the converter |
| adc_mosi | output | 1 | Configuration bit to the converter |
| adc_miso | input | 1 | Result bit from the converter |

## Verification
The bench's converter model changes its output bit only on falling serial clock edges. A sequencer that sampled on the wrong edge, or counted one pulse too few or too many, would return a shifted result and fail the data check. Results are matched against the configuration from one frame earlier, and the first frame after reset must stay silent. A design that tagged results with the current word would report the wrong configuration, and one that emitted a result for the first frame would report a frame that has no owner. Words with the sleep bit set, including all-ones and a lone sleep bit, are sent back to back with other words. A sequencer that restarted after only the acquisition wait would start a conversion before the wake-up time had elapsed. Requests are also held continuously during conversions, so a sequencer that restarted a conversion already under way would show a shortened high phase on the framing line.

// File: rtl/adc_seq_pkg.sv
// Shared types for the multiplexed converter sequencer.
// Assumes the 7-bit configuration is transmitted from its MSB downward.
package adc_seq_pkg;

    localparam int CFG_W = 7;

    // Configuration word; the first member is the first bit on the wire.
    typedef struct packed {
        logic       single_end;
        logic       odd_sign;
        logic [1:0] sel;
        logic       com_ref;
        logic       unipolar;
        logic       sleep;
    } adc_cfg_t;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_CONV = 2'd1,
        ST_XFER = 2'd2
    } seq_state_t;

endpackage

// File: rtl/adc_sck_gen.sv
// Serial clock generator: while run is high, toggles sclk every SCK_DIV
// system clocks, starting low, and flags the cycle of each edge.
// Assumes run is lowered in the cycle after the final falling edge.
module adc_sck_gen #(
    parameter int SCK_DIV = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic sclk,
    output logic rise_p,
    output logic fall_p
);
    localparam int CW = $clog2(SCK_DIV + 1);

    logic [CW-1:0] cnt;
    logic          edge_now;

    assign edge_now = run && (cnt == CW'(SCK_DIV - 1));
    assign rise_p   = edge_now && !sclk;
    assign fall_p   = edge_now && sclk;

    // Count the half period and toggle the serial clock at its end.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt  <= '0;
            sclk <= 1'b0;
        end else if (edge_now) begin
            cnt  <= '0;
            sclk <= ~sclk;
        end else begin
            cnt  <= cnt + 1'b1;
        end
    end

endmodule

// File: rtl/adc_frame_shifter.sv
// Frame shifter: sends the configuration MSB first, advancing on falling
// edges, and collects the result MSB first on rising edges.
// Assumes load is pulsed once while the serial clock is low.
module adc_frame_shifter #(
    parameter int RES_BITS = 16,
    parameter int CFG_W    = 7
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                load,
    input  logic [CFG_W-1:0]    cfg_in,
    input  logic                rise_p,
    input  logic                fall_p,
    input  logic                miso,
    output logic                mosi,
    output logic [RES_BITS-1:0] rx_data,
    output logic                done
);
    localparam int CNT_W = $clog2(RES_BITS + 1);

    logic [CFG_W-1:0] tx_q;
    logic [CNT_W-1:0] bit_cnt;

    assign mosi = tx_q[CFG_W-1];
    assign done = (bit_cnt == CNT_W'(RES_BITS));

    // Load the word, then capture on rising and advance on falling edges.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_q    <= '0;
            rx_data <= '0;
            bit_cnt <= '0;
        end else if (load) begin
            tx_q    <= cfg_in;
            bit_cnt <= '0;
        end else begin
            if (rise_p) begin
                rx_data <= {rx_data[RES_BITS-2:0], miso};
                bit_cnt <= bit_cnt + 1'b1;
            end
            if (fall_p) begin
                tx_q <= {tx_q[CFG_W-2:0], 1'b0};
            end
        end
    end

endmodule

// File: rtl/adc_mux_sequencer.sv
// Host sequencer for a multiplexed serial converter. It starts a
// conversion, waits out the worst-case conversion time, then runs one
// frame that writes the next configuration and reads the result.
// The result is tagged with the configuration of the previous frame.
// Assumes all times are given in system clock cycles and that the
// converter samples its input on rising serial clock edges.
module adc_mux_sequencer #(
    parameter int RES_BITS    = 16,
    parameter int SCK_DIV     = 5,
    parameter int CONV_CYCLES = 185,
    parameter int ACQ_CYCLES  = 101,
    parameter int WAKE_CYCLES = 4000000
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_valid,
    output logic                req_ready,
    input  logic [6:0]          req_cfg,
    output logic                res_valid,
    output logic [RES_BITS-1:0] res_data,
    output logic [6:0]          res_cfg,
    output logic                adc_cnv,
    output logic                adc_sclk,
    output logic                adc_mosi,
    input  logic                adc_miso
);
    import adc_seq_pkg::*;

    localparam int T_A   = (CONV_CYCLES > ACQ_CYCLES) ? CONV_CYCLES : ACQ_CYCLES;
    localparam int T_MAX = (T_A > WAKE_CYCLES) ? T_A : WAKE_CYCLES;
    localparam int TW    = $clog2(T_MAX + 1);

    generate
        if (SCK_DIV < 5) begin : g_div_too_small
            $error("SCK_DIV below 5 exceeds one tenth of the system clock");
        end
        if (RES_BITS < CFG_W) begin : g_res_too_short
            $error("RES_BITS must cover the configuration word");
        end
    endgenerate

    seq_state_t          state;
    logic [TW-1:0]       tmr;
    adc_cfg_t            cur_cfg;
    adc_cfg_t            prev_cfg;
    logic                have_prev;
    logic                run;
    logic                load;
    logic                rise_p;
    logic                fall_p;
    logic                done;
    logic [RES_BITS-1:0] rx_data;

    assign run       = (state == ST_XFER);
    assign load      = (state == ST_CONV) && (tmr == '0);
    assign req_ready = (state == ST_IDLE) && (tmr == '0);

    adc_sck_gen #(
        .SCK_DIV (SCK_DIV)
    ) u_sck (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (run),
        .sclk   (adc_sclk),
        .rise_p (rise_p),
        .fall_p (fall_p)
    );

    adc_frame_shifter #(
        .RES_BITS (RES_BITS),
        .CFG_W    (CFG_W)
    ) u_shift (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (load),
        .cfg_in  (cur_cfg),
        .rise_p  (rise_p),
        .fall_p  (fall_p),
        .miso    (adc_miso),
        .mosi    (adc_mosi),
        .rx_data (rx_data),
        .done    (done)
    );

    // Frame sequencing: idle gap, conversion wait, transfer, result hand-off.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            tmr       <= '0;
            adc_cnv   <= 1'b0;
            cur_cfg   <= '0;
            prev_cfg  <= '0;
            have_prev <= 1'b0;
            res_valid <= 1'b0;
            res_data  <= '0;
            res_cfg   <= '0;
        end else begin
            res_valid <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (tmr != '0) begin
                        tmr <= tmr - 1'b1;
                    end else if (req_valid) begin
                        cur_cfg <= adc_cfg_t'(req_cfg);
                        adc_cnv <= 1'b1;
                        tmr     <= TW'(CONV_CYCLES - 1);
                        state   <= ST_CONV;
                    end
                end
                ST_CONV: begin
                    if (tmr == '0) begin
                        adc_cnv <= 1'b0;
                        state   <= ST_XFER;
                    end else begin
                        tmr <= tmr - 1'b1;
                    end
                end
                ST_XFER: begin
                    if (fall_p && done) begin
                        state     <= ST_IDLE;
                        tmr       <= cur_cfg.sleep ? TW'(WAKE_CYCLES) : TW'(ACQ_CYCLES);
                        res_valid <= have_prev;
                        res_data  <= rx_data;
                        res_cfg   <= prev_cfg;
                        prev_cfg  <= cur_cfg;
                        have_prev <= 1'b1;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/adc_seq_checker.sv
// Protocol checker for the sequencer pins; bound into every instance.
// Assumes the parameters match the bound instance.
module adc_seq_checker #(
    parameter int CONV_CYCLES = 185,
    parameter int ACQ_CYCLES  = 101
) (
    input logic clk,
    input logic rst_n,
    input logic cnv,
    input logic sclk,
    input logic mosi,
    input logic req_ready,
    input logic res_valid
);
    logic [31:0] hi_cnt;
    logic [31:0] idle_cnt;
    logic        seen_frame;

    // Length of the current high phase of the framing line.
    always_ff @(posedge clk) begin
        if (!rst_n) hi_cnt <= '0;
        else        hi_cnt <= cnv ? hi_cnt + 1'b1 : '0;
    end

    // Quiet cycles since the last serial clock activity.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idle_cnt   <= '0;
            seen_frame <= 1'b0;
        end else begin
            if (sclk || cnv)                 idle_cnt <= '0;
            else if (idle_cnt != 32'hFFFF_FFFF) idle_cnt <= idle_cnt + 1'b1;
            if (sclk) seen_frame <= 1'b1;
        end
    end

    // R2
    conv_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cnv) |-> (hi_cnt == 32'(CONV_CYCLES)));

    // R2
    no_sclk_in_conv_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnv |-> !sclk);

    // R2
    no_ready_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnv |-> !req_ready);

    // R4
    mosi_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sclk && $past(sclk)) |-> $stable(mosi));

    // R6
    res_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |=> !res_valid);

    // R7
    acq_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(cnv) && seen_frame) |-> (idle_cnt >= 32'(ACQ_CYCLES)));

endmodule

bind adc_mux_sequencer adc_seq_checker #(
    .CONV_CYCLES (CONV_CYCLES),
    .ACQ_CYCLES  (ACQ_CYCLES)
) u_seq_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cnv       (adc_cnv),
    .sclk      (adc_sclk),
    .mosi      (adc_mosi),
    .req_ready (req_ready),
    .res_valid (res_valid)
);

// File: tb/adc_mux_sequencer_bench.sv
// Bench: converter model on the serial pins, directed and random requests.
module adc_mux_sequencer_bench;
    localparam int RES  = 16;
    localparam int DIV  = 5;
    localparam int CONV = 12;
    localparam int ACQ  = 9;
    localparam int WAKE = 400;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           req_valid = 1'b0;
    logic [6:0]     req_cfg = '0;
    logic           adc_miso = 1'b0;
    logic           req_ready;
    logic           res_valid;
    logic [RES-1:0] res_data;
    logic [6:0]     res_cfg;
    logic           adc_cnv;
    logic           adc_sclk;
    logic           adc_mosi;

    always #10 clk = ~clk;

    adc_mux_sequencer #(
        .RES_BITS    (RES),
        .SCK_DIV     (DIV),
        .CONV_CYCLES (CONV),
        .ACQ_CYCLES  (ACQ),
        .WAKE_CYCLES (WAKE)
    ) u_adc_mux_sequencer (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_ready (req_ready),
        .req_cfg   (req_cfg),
        .res_valid (res_valid),
        .res_data  (res_data),
        .res_cfg   (res_cfg),
        .adc_cnv   (adc_cnv),
        .adc_sclk  (adc_sclk),
        .adc_mosi  (adc_mosi),
        .adc_miso  (adc_miso)
    );

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;
    logic [RES-1:0] conv_val [0:127];
    logic [6:0]     cfg_sent [0:127];
    int nsent = 0;
    int nconv = 0;
    int nres  = 0;

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Minimum quiet time owed after a frame, from R7 and R8.
    function automatic int gap_need(input bit slept);
        return slept ? WAKE : ACQ;
    endfunction

    // Converter model and pin monitor, sampled on falling clock edges.
    initial begin
        longint cyc = 0, rise_cyc = 0, edge_cyc = 0, end_cyc = 0;
        int frame_bits = 0;
        logic [6:0] got_cfg = '0;
        bit last_sleep = 1'b0;
        logic p_cnv = 1'b0, p_sclk = 1'b0, p_mosi = 1'b0, p_resv = 1'b0;
        wait (rst_n);
        forever begin
            @(negedge clk);
            cyc++;
            if (adc_cnv && adc_sclk) check(1'b0, "R2", "sclk during conversion", 1, 0);
            if (adc_cnv && req_ready) check(1'b0, "R2", "ready during conversion", 1, 0);
            if (adc_cnv && !p_cnv) begin
                check(nsent == nconv + 1, "R2", "one start per request", nconv + 1, nsent);
                if (nconv > 0) begin
                    check(frame_bits == RES, "R3", "pulses per frame", frame_bits, RES);
                    check(cyc - end_cyc >= gap_need(last_sleep), last_sleep ? "R8" : "R7",
                          "quiet gap", cyc - end_cyc, gap_need(last_sleep));
                end
                conv_val[nconv] = RES'($urandom);
                nconv++;
                rise_cyc   = cyc;
                frame_bits = 0;
                got_cfg    = '0;
            end
            if (!adc_cnv && p_cnv) begin
                check(cyc - rise_cyc == CONV, "R2", "convert high time", cyc - rise_cyc, CONV);
                adc_miso = conv_val[nconv-1][RES-1];
                edge_cyc = cyc;
            end
            if (adc_sclk && !p_sclk) begin
                check(cyc - edge_cyc == DIV, "R3", "low phase", cyc - edge_cyc, DIV);
                edge_cyc = cyc;
                if (frame_bits < 7) got_cfg = {got_cfg[5:0], adc_mosi};
                else check(!adc_mosi, "R4", "mosi after word", adc_mosi, 0);
                frame_bits++;
            end
            if (!adc_sclk && p_sclk) begin
                check(cyc - edge_cyc == DIV, "R3", "high phase", cyc - edge_cyc, DIV);
                edge_cyc = cyc;
                if (frame_bits == RES) begin
                    end_cyc = cyc;
                    check(got_cfg == cfg_sent[nconv-1], "R4", "word received",
                          got_cfg, cfg_sent[nconv-1]);
                    last_sleep = got_cfg[0];
                    adc_miso = 1'b0;
                end else if (frame_bits < RES) begin
                    adc_miso = conv_val[nconv-1][RES-1-frame_bits];
                end
            end
            if (adc_sclk && p_sclk && adc_mosi != p_mosi)
                check(1'b0, "R4", "mosi moved while sclk high", adc_mosi, p_mosi);
            if (res_valid) begin
                check(nconv >= 2, "R6", "result after first frame", nconv, 2);
                check(cyc == end_cyc, "R6", "strobe cycle", cyc, end_cyc);
                check(!p_resv, "R6", "single-cycle strobe", p_resv, 0);
                check(res_data == conv_val[nconv-1], "R5", "result data",
                      res_data, conv_val[nconv-1]);
                if (nconv >= 2)
                    check(res_cfg == cfg_sent[nconv-2], "R6", "result tag",
                          res_cfg, cfg_sent[nconv-2]);
                nres++;
            end
            p_cnv  = adc_cnv;
            p_sclk = adc_sclk;
            p_mosi = adc_mosi;
            p_resv = res_valid;
        end
    end

    task automatic send(input logic [6:0] c, input int idle);
        repeat (idle) @(negedge clk);
        @(negedge clk);
        req_valid = 1'b1;
        req_cfg   = c;
        while (!req_ready) @(negedge clk);
        cfg_sent[nsent] = c;
        nsent++;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    // Stimulus: reset, directed words, then seeded random words.
    initial begin
        int unused_seed;
        unused_seed = $urandom(32'h1C0DE);
        repeat (4) @(negedge clk);
        check(!adc_cnv && !adc_sclk && !res_valid && !adc_mosi, "R1", "outputs in reset",
              {adc_cnv, adc_sclk, res_valid, adc_mosi}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(req_ready, "R1", "ready after reset", req_ready, 1);
        check(!adc_cnv && !adc_sclk && !res_valid, "R1", "idle after reset",
              {adc_cnv, adc_sclk, res_valid}, 0);
        send(7'h00, 0);
        send(7'h7F, 0);
        send(7'h40, 3);
        send(7'h2A, 0);
        send(7'h01, 0);
        send(7'h55, 1);
        for (int i = 0; i < 40; i++) begin
            logic [6:0] c;
            c    = 7'($urandom);
            c[0] = ($urandom % 4) == 0;
            send(c, $urandom % 25);
        end
        for (int i = 0; i < 2000; i++) begin
            @(negedge clk);
            if (req_ready && nres == nsent - 1) break;
        end
        check(nres == nsent - 1, "R6", "result count", nres, nsent - 1);
        check(nconv == nsent, "R2", "conversion count", nconv, nsent);
        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule